// File: doc/BRIEF.md
# Multi-channel DMA interrupt controller

This block holds the interrupt status and interrupt enable registers for an eight-channel Ethernet MAC DMA engine. Each channel owns one status register and one enable register. DMA event sources report completions and errors as single-cycle pulses. Each pulse latches a sticky cause bit in its channel's status register. Software reads these registers and clears cause bits through a simple single-cycle register bus. Writing 1 to a bit clears it, and writing 0 to a bit has no effect.

The normal, abnormal and fatal-bus-error summaries are kept separately for the transmit and receive directions. Each summary bit is derived from its own direction's enabled cause bits. Each channel drives two message-interrupt vectors: one for receive and one for transmit. The vectors are laid out in reversed channel order. A common MAC interrupt on vector 0 collects the activity of all channels. A read-only version word identifies the multi-channel variant.

Top module: `mcdma_irq_ctrl`

## Requirements
- R1: After reset every status register and every enable register reads 0, and all vector outputs are 0.
- R2: An event pulse on input bit b of channel c sets status bit b of that channel on the next clock edge. The bit stays set until it is cleared. Cause bits are 0–10 and 12–14. Input bit 11 has no cause and is ignored, so status bit 11 reads 0.
- R3: A status write clears each cause bit whose write-data bit is 1 and leaves each cause bit whose write-data bit is 0 unchanged.
- R4: If an event pulse and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R5: The enable register holds the cause enables in bits 0–10 and 12–14. It holds the summary enables in bits 18 (transmit normal), 17 (receive normal), 16 (transmit abnormal) and 15 (receive abnormal). All other bits read 0, so writing all ones reads back 0x0007F7FF.
- R6: A status summary bit reads 1 when any cause in its group is both set and enabled. Bit 18 (transmit normal) covers causes 0 (transmit done) and 2 (transmit buffer unavailable). Bit 17 (receive normal) covers causes 6 (receive done) and 14 (early receive). Bit 16 (transmit abnormal) covers causes 1, 3, 5, 10 and 13 (transmit fatal bus error). Bit 15 (receive abnormal) covers causes 4, 7, 8, 9 and 12 (receive fatal bus error).
- R7: Status bits 15 to 18 are not affected by writes. They change only as the underlying causes and enables change.
- R8: The receive vector of channel c is output bit 15−2c, and the transmit vector is output bit 16−2c. A vector is 1 while its direction has a normal or abnormal summary set whose summary enable is also set.
- R9: Vector 0 is the OR of all channel vectors. Output bits 17 to 31 are always 0.
- R10: Register 2 of any channel reads 0x00000010, and writes to it have no effect.
- R11: Events and writes aimed at one channel change no other channel's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 120 | Event pulses, 15 bits per channel; channel c uses bits 15c+14..15c |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Bits 4:2 select the channel; bits 1:0 select the register (0 status, 1 enable, 2 version, 3 reads 0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, available combinationally |
| msi_vec | output | 32 | Message-interrupt vector lines |

## Verification
A lost or stuck cause bit shows up on the status read one cycle after the pulse that should have set it. In the same cycle, the summary bit and the direction's vector line also disagree with expectations. A wrong group assignment, or a wrong vector index, lights a summary bit or a vector bit other than the one expected. This shows up as soon as the corresponding cause is pulsed. Leakage between channels appears as a nonzero read of a neighbouring channel's status word. A broken clear shows up as a bit that survives a write of 1, or disappears after a write of 0, at the next read.

// File: rtl/mcdma_irq_pkg.sv
package mcdma_irq_pkg;

  localparam int EVW = 15;
  localparam int DW  = 32;

  localparam logic [EVW-1:0] CAUSE_MASK = 15'h77FF;
  localparam logic [EVW-1:0] GRP_TXN    = 15'h0005;
  localparam logic [EVW-1:0] GRP_RXN    = 15'h4040;
  localparam logic [EVW-1:0] GRP_TXA    = 15'h242A;
  localparam logic [EVW-1:0] GRP_RXA    = 15'h1390;

  typedef struct packed {
    logic txn;
    logic rxn;
    logic txa;
    logic rxa;
  } sum_t;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_ENA  = 2'd1,
    REG_VER  = 2'd2,
    REG_RSV  = 2'd3
  } reg_sel_e;

  function automatic logic grp_hit(input logic [EVW-1:0] cause,
                                   input logic [EVW-1:0] en,
                                   input logic [EVW-1:0] grp);
    return |(cause & en & grp);
  endfunction

  function automatic sum_t summarize(input logic [EVW-1:0] cause,
                                     input logic [EVW-1:0] en);
    sum_t s;
    s.txn = grp_hit(cause, en, GRP_TXN);
    s.rxn = grp_hit(cause, en, GRP_RXN);
    s.txa = grp_hit(cause, en, GRP_TXA);
    s.rxa = grp_hit(cause, en, GRP_RXA);
    return s;
  endfunction

  function automatic int rx_vec_idx(input int c, input int nch);
    return 2 * nch - 1 - 2 * c;
  endfunction

  function automatic int tx_vec_idx(input int c, input int nch);
    return 2 * nch - 2 * c;
  endfunction

endpackage

// File: rtl/mcdma_bus_dec.sv
module mcdma_bus_dec
  import mcdma_irq_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = 3
)(
  input  logic              bus_wr,
  input  logic [CH_W+1:0]   bus_addr,
  output logic [NCH-1:0]    wr_stat,
  output logic [NCH-1:0]    wr_ena,
  output logic [CH_W-1:0]   sel_ch,
  output reg_sel_e          sel_reg
);

  assign sel_ch  = bus_addr[CH_W+1:2];
  assign sel_reg = reg_sel_e'(bus_addr[1:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic ch_hit;
    assign ch_hit     = bus_wr && (sel_ch == CH_W'(c));
    assign wr_stat[c] = ch_hit && (sel_reg == REG_STAT);
    assign wr_ena[c]  = ch_hit && (sel_reg == REG_ENA);
  end

endmodule

// File: rtl/mcdma_chan_regs.sv
module mcdma_chan_regs
  import mcdma_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EVW-1:0]  evt,
  input  logic            wr_stat,
  input  logic            wr_ena,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   stat_word,
  output logic [DW-1:0]   ena_word,
  output logic [EVW-1:0]  cause_o,
  output logic            rx_req,
  output logic            tx_req
);

  logic [EVW-1:0] cause_q;
  logic [EVW-1:0] en_cause_q;
  sum_t           en_sum_q;
  logic [EVW-1:0] set_ev;
  logic [EVW-1:0] clr_wr;
  sum_t           sum;

  assign set_ev = evt & CAUSE_MASK;
  assign clr_wr = wr_stat ? (wdata[EVW-1:0] & CAUSE_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else begin
      cause_q <= (cause_q & ~clr_wr) | set_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_cause_q <= '0;
      en_sum_q   <= '0;
    end else if (wr_ena) begin
      en_cause_q <= wdata[EVW-1:0] & CAUSE_MASK;
      en_sum_q   <= sum_t'(wdata[EVW+3:EVW]);
    end
  end

  assign sum       = summarize(cause_q, en_cause_q);
  assign rx_req    = (sum.rxn & en_sum_q.rxn) | (sum.rxa & en_sum_q.rxa);
  assign tx_req    = (sum.txn & en_sum_q.txn) | (sum.txa & en_sum_q.txa);
  assign stat_word = {13'd0, sum, cause_q};
  assign ena_word  = {13'd0, en_sum_q, en_cause_q};
  assign cause_o   = cause_q;

endmodule

// File: rtl/mcdma_vec_route.sv
module mcdma_vec_route
  import mcdma_irq_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NVEC = 32
)(
  input  logic [NCH-1:0]  rx_req,
  input  logic [NCH-1:0]  tx_req,
  output logic [NVEC-1:0] vec
);

  always_comb begin
    vec    = '0;
    for (int c = 0; c < NCH; c++) begin
      vec[rx_vec_idx(c, NCH)] = rx_req[c];
      vec[tx_vec_idx(c, NCH)] = tx_req[c];
    end
    vec[0] = (|rx_req) | (|tx_req);
  end

endmodule

// File: rtl/mcdma_irq_ctrl.sv
module mcdma_irq_ctrl
  import mcdma_irq_pkg::*;
#(
  parameter int          NCH    = 8,
  parameter int          NVEC   = 32,
  parameter logic [7:0]  VER_ID = 8'h10,
  localparam int         CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int         ADDR_W = CH_W + 2
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH*EVW-1:0]  evt_i,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [NVEC-1:0]     msi_vec
);

  logic [NCH-1:0]     wr_stat;
  logic [NCH-1:0]     wr_ena;
  logic [CH_W-1:0]    sel_ch;
  reg_sel_e           sel_reg;
  logic [NCH-1:0]     rx_req;
  logic [NCH-1:0]     tx_req;
  logic [DW-1:0]      stat_word [NCH];
  logic [DW-1:0]      ena_word  [NCH];
  logic [NCH*EVW-1:0] cause_all;

  mcdma_bus_dec #(.NCH(NCH), .CH_W(CH_W)) u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wr_stat (wr_stat),
    .wr_ena  (wr_ena),
    .sel_ch  (sel_ch),
    .sel_reg (sel_reg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mcdma_chan_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i[c*EVW +: EVW]),
      .wr_stat  (wr_stat[c]),
      .wr_ena   (wr_ena[c]),
      .wdata    (bus_wdata),
      .stat_word(stat_word[c]),
      .ena_word (ena_word[c]),
      .cause_o  (cause_all[c*EVW +: EVW]),
      .rx_req   (rx_req[c]),
      .tx_req   (tx_req[c])
    );
  end

  mcdma_vec_route #(.NCH(NCH), .NVEC(NVEC)) u_route (
    .rx_req(rx_req),
    .tx_req(tx_req),
    .vec   (msi_vec)
  );

  always_comb begin
    bus_rdata = '0;
    if (int'(sel_ch) < NCH) begin
      unique case (sel_reg)
        REG_STAT: bus_rdata = stat_word[sel_ch];
        REG_ENA:  bus_rdata = ena_word[sel_ch];
        REG_VER:  bus_rdata = {24'd0, VER_ID};
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mcdma_irq_chk.sv
module mcdma_irq_chk
  import mcdma_irq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int NVEC   = 32,
  parameter int ADDR_W = 5
)(
  input logic                clk,
  input logic                rst_n,
  input logic [NCH*EVW-1:0]  evt_i,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic [NVEC-1:0]     msi_vec,
  input logic [NCH*EVW-1:0]  cause_all
);

  // R9
  vec0_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_vec[0] == (|msi_vec[NVEC-1:1]));

  if (NVEC > 2*NCH + 1) begin : g_unused
    // R9
    unused_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msi_vec[NVEC-1:2*NCH+1] == '0);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic stat_hit;
    assign stat_hit = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(c))
                      && (bus_addr[1:0] == 2'd0);
    for (genvar b = 0; b < EVW; b++) begin : g_b
      if (CAUSE_MASK[b]) begin : g_live
        // R2 R4
        evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
          evt_i[c*EVW+b] |=> cause_all[c*EVW+b]);
        // R3
        clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (stat_hit && bus_wdata[b] && !evt_i[c*EVW+b]) |=> !cause_all[c*EVW+b]);
        // R3 R11
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (!evt_i[c*EVW+b] && !(stat_hit && bus_wdata[b])) |=> $stable(cause_all[c*EVW+b]));
      end
    end
  end

endmodule

bind mcdma_irq_ctrl mcdma_irq_chk #(.NCH(NCH), .NVEC(NVEC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_i    (evt_i),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .msi_vec  (msi_vec),
  .cause_all(cause_all)
);

// File: tb/sim_mcdma_irq_ctrl.sv
`timescale 1ns/1ps
module sim_mcdma_irq_ctrl;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [119:0] evt_i = '0;
  logic         bus_wr = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [31:0]  msi_vec;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mcdma_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msi_vec(msi_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] adr(input int c, input int r);
    return 5'(c * 4 + r);
  endfunction

  task automatic rd(input int c, input int r, output logic [31:0] v);
    bus_addr = adr(c, r);
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input int c, input int r, input logic [31:0] d);
    @(negedge clk);
    bus_addr = adr(c, r); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(input int c, input int b);
    @(negedge clk);
    evt_i[c*15+b] = 1'b1;
    @(negedge clk);
    evt_i = '0;
  endtask

  // group of a cause bit: 3 txn(18), 2 rxn(17), 1 txa(16), 0 rxa(15), -1 none
  function automatic int grp(input int b);
    case (b)
      0, 2:               return 3;
      6, 14:              return 2;
      1, 3, 5, 10, 13:    return 1;
      4, 7, 8, 9, 12:     return 0;
      default:            return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_stat(input logic [14:0] cz, input logic [31:0] en);
    logic [31:0] s;
    s = {17'd0, cz};
    for (int b = 0; b < 15; b++)
      if (cz[b] && en[b] && grp(b) >= 0) s[15 + grp(b)] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] exp_vec(input int c, input logic [31:0] s, input logic [31:0] en);
    logic [31:0] v;
    logic rx, tx;
    v  = '0;
    rx = (s[17] & en[17]) | (s[15] & en[15]);
    tx = (s[18] & en[18]) | (s[16] & en[16]);
    v[15 - 2*c] = rx;
    v[16 - 2*c] = tx;
    v[0] = rx | tx;
    return v;
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, e, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 8; c++) begin
      rd(c, 0, v); chk("R1 status", v, 32'h0);
      rd(c, 1, v); chk("R1 enable", v, 32'h0);
    end
    chk("R1 vectors", msi_vec, 32'h0);

    // R10 version
    rd(2, 2, v); chk("R10 version", v, 32'h10);
    wr(2, 2, 32'hFFFF_FFFF);
    rd(5, 2, v); chk("R10 version after write", v, 32'h10);
    rd(5, 3, v); chk("R10 reserved reg", v, 32'h0);

    // R5 enable read back
    for (int c = 0; c < 8; c++) begin
      wr(c, 1, 32'hFFFF_FFFF);
      rd(c, 1, v); chk("R5 enable mask", v, 32'h0007_F7FF);
      wr(c, 1, 32'h0);
    end

    // sweep every channel and cause bit
    for (int c = 0; c < 8; c++) begin
      wr(c, 1, 32'hFFFF_FFFF);
      for (int b = 0; b < 15; b++) begin
        logic [14:0] cz;
        cz = (b == 11) ? 15'h0 : 15'(1 << b);
        pulse(c, b);
        e = exp_stat(cz, 32'h0007_F7FF);
        rd(c, 0, v); chk("R2 R6 status after event", v, e);
        chk("R8 R9 vector", msi_vec, exp_vec(c, e, 32'h0007_F7FF));
        rd((c + 1) % 8, 0, v); chk("R11 other channel", v, 32'h0);
        wr(c, 0, 32'h0);
        rd(c, 0, v); chk("R3 write 0 keeps", v, e);
        wr(c, 0, 32'h0007_8000);
        rd(c, 0, v); chk("R7 summary write no effect", v, e);
        wr(c, 0, 32'(1 << b));
        rd(c, 0, v); chk("R3 write 1 clears", v, 32'h0);
      end
      wr(c, 1, 32'h0);
    end

    // R6 R8 gating by enables, channel 3 receive done
    wr(3, 1, 32'h0000_77FF);
    pulse(3, 6);
    rd(3, 0, v); chk("R6 summary with cause enable", v, 32'h0002_0040);
    chk("R8 no summary enable no vector", msi_vec, 32'h0);
    wr(3, 1, 32'h0007_8000);
    rd(3, 0, v); chk("R6 cause disabled no summary", v, 32'h0000_0040);
    chk("R8 vector off", msi_vec, 32'h0);
    wr(3, 1, 32'h0007_F7FF);
    chk("R8 ch3 rx vector 9", msi_vec, 32'h0000_0201);
    wr(3, 0, 32'h0000_0040);
    chk("R8 vector drops after clear", msi_vec, 32'h0);
    wr(3, 1, 32'h0);

    // R4 event and clear in the same cycle
    wr(5, 1, 32'h0007_F7FF);
    @(negedge clk);
    evt_i[5*15+0] = 1'b1;
    bus_addr = adr(5, 0); bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    evt_i = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(5, 0, v); chk("R4 event beats clear", v, 32'h0004_0001);
    @(negedge clk);
    evt_i[5*15+0] = 1'b1;
    bus_addr = adr(5, 0); bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    evt_i = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(5, 0, v); chk("R4 set bit with event and clear", v, 32'h0004_0001);
    chk("R8 ch5 tx vector 6", msi_vec, 32'h0000_0041);
    wr(5, 0, 32'h1);
    wr(5, 1, 32'h0);

    // R8 R9 two channels together: ch0 rx done, ch7 tx underflow
    wr(0, 1, 32'h0007_F7FF);
    wr(7, 1, 32'h0007_F7FF);
    @(negedge clk);
    evt_i[0*15+6] = 1'b1;
    evt_i[7*15+5] = 1'b1;
    @(negedge clk);
    evt_i = '0;
    chk("R8 R9 ch0 rx and ch7 tx", msi_vec, 32'h0000_8005);
    rd(7, 0, s); chk("R6 ch7 tx abnormal", s, 32'h0001_0020);
    wr(0, 0, 32'hFFFF_FFFF);
    chk("R8 only ch7 left", msi_vec, 32'h0000_0005);
    wr(7, 0, 32'hFFFF_FFFF);
    chk("R9 all clear", msi_vec, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule